// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block decides how a small microcontroller core is clocked. Software picks a clock source and ratio through a select field. Values zero to six run the core from the high-speed oscillator divided by a power of two. The all-ones value runs it from the low-speed oscillator. A halt request parks the core in one of four low-power states. Two idle-enable bits choose which oscillators keep running in that state. A wake event brings the core back to the running mode that the select field names.

The high-speed oscillator is shut down whenever nothing needs it. When a mode change needs it again, the controller waits for its stable flag before moving the core onto it. During that wait the core keeps running from the low-speed clock and a busy flag is raised. The oscillators are represented only by their enable outputs and the stable input. The system clock is delivered as a one-cycle clock-enable strobe `sys_ce` in the `clk` domain. A new divide ratio takes effect only at the end of a divided period, so no period is ever cut short.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, the block is in the oscillator wait state: `busy`=1, `mode`=1, `hi_osc_en`=1, `lo_osc_en`=1, `cpu_clk_en`=1 and `sys_ce`=0.
- R2: With `clk_sel`=7 the block enters SLOW (`mode`=1) on the next clock. In SLOW, `hi_osc_en`=0, `lo_osc_en`=1 and `busy`=0. `sys_ce` gives one pulse for each rising edge of `lo_clk_in`, so the pulse spacing equals the low clock period.
- R3: In FAST (`mode`=0) with `clk_sel`=k, where k is 0 to 6, `sys_ce` pulses once every 2^k `clk` cycles.
- R4: A change of `clk_sel` within FAST does not alter the divided period in progress. The new ratio applies from the next period boundary.
- R5: A halt request picks the halt mode from {`idle_hi_en`,`idle_lo_en`}: 00 gives SLEEP (`mode`=2, both oscillators off), 01 gives IDLE0 (`mode`=3, only low on), 11 gives IDLE1 (`mode`=4, both on), and 10 gives IDLE2 (`mode`=5, only high on). The mode is visible one clock after the request.
- R6: In every halt mode `cpu_clk_en`=0 and `sys_ce` stays low.
- R7: A wake event in a halt mode leads to SLOW when `clk_sel`=7. It leads to FAST when the high-speed oscillator is stable. Otherwise it leads to the wait state (`mode`=1, `busy`=1). The result is visible one clock after the wake.
- R8: Leaving SLOW for a ratio value enters the wait state when `hi_stable` is low. In that state `hi_osc_en`=1, `busy`=1 and `sys_ce` follows the low clock. The block moves to FAST one clock after `hi_stable` is seen high, and never enters FAST without it.
- R9: A halt request has priority over a `clk_sel` change in the same cycle. `wake` is ignored outside halt modes, and `halt_req` is ignored during the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Clock select: 0..6 ratio exponent, 7 low-speed source |
| idle_hi_en | input | 1 | Keep high-speed oscillator on in halt |
| idle_lo_en | input | 1 | Keep low-speed oscillator on in halt |
| halt_req | input | 1 | Halt request, sampled each clock |
| wake | input | 1 | Wake event, sampled each clock |
| hi_stable | input | 1 | High-speed oscillator stable flag |
| lo_clk_in | input | 1 | Low-speed clock level, synchronised inside |
| mode | output | 3 | 0 FAST, 1 SLOW/wait, 2 SLEEP, 3 IDLE0, 4 IDLE1, 5 IDLE2 |
| hi_osc_en | output | 1 | High-speed oscillator enable |
| lo_osc_en | output | 1 | Low-speed oscillator enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| sys_ce | output | 1 | System clock strobe |
| busy | output | 1 | Waiting for high-speed oscillator stability |

## Verification
Mode, oscillator enables, `busy` and `cpu_clk_en` decode directly from the state register, so they change one clock after `halt_req`, `wake` or `clk_sel`. The bench drives on the falling edge and checks at the next falling edge. `sys_ce` is registered, and on the low source it trails each `lo_clk_in` rise by three clocks. The checks therefore measure the spacing between consecutive strobes rather than absolute phase, and they discard the first interval after a ratio change unless that interval is the point of the check. The oscillator wait has a modelled duration, so the bench waits for `busy` to fall under a timeout and then checks that FAST follows.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_FAST  = 3'd0,
    ST_SLOW  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_IDLE0 = 3'd3,
    ST_IDLE1 = 3'd4,
    ST_IDLE2 = 3'd5,
    ST_WARM  = 3'd6
  } pmc_state_e;

  // Halt target from the two keep-running bits {high, low}
  function automatic pmc_state_e halt_target(input logic keep_hi, input logic keep_lo);
    pmc_state_e t;
    unique case ({keep_hi, keep_lo})
      2'b00:   t = ST_SLEEP;
      2'b01:   t = ST_IDLE0;
      2'b11:   t = ST_IDLE1;
      default: t = ST_IDLE2;
    endcase
    return t;
  endfunction

  function automatic logic is_halt(input pmc_state_e s);
    return (s == ST_SLEEP) || (s == ST_IDLE0) || (s == ST_IDLE1) || (s == ST_IDLE2);
  endfunction

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pmc_lo_sync.sv
module pmc_lo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_level,
  output logic lo_rise
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], lo_level};
  end

  assign lo_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2
  lo_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rise |=> !lo_rise);

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int SEL_W   = 3,
  parameter int EXP_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             term
);

  localparam int CNT_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [SEL_W-1:0] sel_eff;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask;
  logic             load;

  assign sel_eff = (sel_in > SEL_W'(EXP_MAX)) ? SEL_W'(EXP_MAX) : sel_in;
  assign mask    = CNT_W'((32'd1 << sel_q) - 32'd1);
  assign term    = run && (cnt_q == mask);
  assign load    = !run || term;

  always_comb begin
    sel_d = sel_q;
    cnt_d = cnt_q + CNT_W'(1);
    if (load) begin
      sel_d = sel_eff;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !term) |=> $stable(sel_q));

  // R3
  term_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && sel_q != '0) |=> !term);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_slow,
  input  logic       idle_hi_en,
  input  logic       idle_lo_en,
  input  logic       halt_req,
  input  logic       wake,
  input  logic       hi_stable,
  output logic [2:0] mode_o,
  output logic       hi_osc_en_o,
  output logic       lo_osc_en_o,
  output logic       cpu_clk_en_o,
  output logic       busy_o,
  output logic       src_hi_o,
  output logic       src_lo_o
);

  pmc_state_e state_q, state_d;
  logic       state_en;

  // Resume target when the core restarts
  pmc_state_e run_target;
  assign run_target = sel_slow ? ST_SLOW : (hi_stable ? ST_FAST : ST_WARM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FAST: begin
        if (halt_req)      state_d = halt_target(idle_hi_en, idle_lo_en);
        else if (sel_slow) state_d = ST_SLOW;
      end
      ST_SLOW: begin
        if (halt_req)       state_d = halt_target(idle_hi_en, idle_lo_en);
        else if (!sel_slow) state_d = run_target;
      end
      ST_WARM: begin
        if (sel_slow)       state_d = ST_SLOW;
        else if (hi_stable) state_d = ST_FAST;
      end
      ST_SLEEP, ST_IDLE0, ST_IDLE1, ST_IDLE2: begin
        if (wake) state_d = run_target;
      end
      default: state_d = ST_WARM;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_WARM;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    hi_osc_en_o  = 1'b0;
    lo_osc_en_o  = 1'b0;
    cpu_clk_en_o = 1'b0;
    busy_o       = 1'b0;
    src_hi_o     = 1'b0;
    src_lo_o     = 1'b0;
    unique case (state_q)
      ST_FAST:  begin hi_osc_en_o = 1'b1; lo_osc_en_o = 1'b1; cpu_clk_en_o = 1'b1; src_hi_o = 1'b1; end
      ST_SLOW:  begin lo_osc_en_o = 1'b1; cpu_clk_en_o = 1'b1; src_lo_o = 1'b1; end
      ST_WARM:  begin hi_osc_en_o = 1'b1; lo_osc_en_o = 1'b1; cpu_clk_en_o = 1'b1; src_lo_o = 1'b1; busy_o = 1'b1; end
      ST_IDLE0: lo_osc_en_o = 1'b1;
      ST_IDLE1: begin hi_osc_en_o = 1'b1; lo_osc_en_o = 1'b1; end
      ST_IDLE2: hi_osc_en_o = 1'b1;
      default:  ;
    endcase
  end

  assign mode_o = (state_q == ST_WARM) ? 3'd1 : 3'(state_q);

  // R8
  fast_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAST && $past(state_q) != ST_FAST) |-> $past(hi_stable));

  // R8
  warm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WARM && hi_stable) |=> !busy_o);

  // R6
  halt_gates_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FAST || state_q == ST_SLOW) && halt_req) |=> !cpu_clk_en_o);

  // R7
  wake_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_halt(state_q) && wake) |=> cpu_clk_en_o);

  // R9
  warm_ignores_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WARM && !sel_slow && !hi_stable) |=> busy_o);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             idle_hi_en,
  input  logic             idle_lo_en,
  input  logic             halt_req,
  input  logic             wake,
  input  logic             hi_stable,
  input  logic             lo_clk_in,
  output logic [2:0]       mode,
  output logic             hi_osc_en,
  output logic             lo_osc_en,
  output logic             cpu_clk_en,
  output logic             sys_ce,
  output logic             busy
);

  localparam int                EXP_MAX   = (1 << SEL_W) - 2;
  localparam logic [SEL_W-1:0]  SLOW_CODE = {SEL_W{1'b1}};

  logic rst_i_n;
  logic lo_rise;
  logic div_term;
  logic src_hi, src_lo;
  logic ce_d, ce_q;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pmc_lo_sync #(.STAGES(SYNC_STAGES)) u_lo_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .lo_level (lo_clk_in),
    .lo_rise  (lo_rise)
  );

  pmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .sel_slow     (clk_sel == SLOW_CODE),
    .idle_hi_en   (idle_hi_en),
    .idle_lo_en   (idle_lo_en),
    .halt_req     (halt_req),
    .wake         (wake),
    .hi_stable    (hi_stable),
    .mode_o       (mode),
    .hi_osc_en_o  (hi_osc_en),
    .lo_osc_en_o  (lo_osc_en),
    .cpu_clk_en_o (cpu_clk_en),
    .busy_o       (busy),
    .src_hi_o     (src_hi),
    .src_lo_o     (src_lo)
  );

  pmc_clk_div #(.SEL_W(SEL_W), .EXP_MAX(EXP_MAX)) u_div (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run    (src_hi),
    .sel_in (clk_sel),
    .term   (div_term)
  );

  always_comb begin
    ce_d = 1'b0;
    if (src_hi)      ce_d = div_term;
    else if (src_lo) ce_d = lo_rise;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ce_q <= 1'b0;
    else          ce_q <= ce_d;
  end

  assign sys_ce = ce_q;

  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cpu_clk_en |=> !sys_ce);

  // R2
  slow_osc_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == 3'd1 && !busy) |-> (!hi_osc_en && lo_osc_en));

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int WARM_CYC = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic       idle_hi_en, idle_lo_en, halt_req, wake;
  logic       hi_stable = 1'b0;
  logic       lo_clk_in = 1'b0;
  logic [2:0] mode;
  logic       hi_osc_en, lo_osc_en, cpu_clk_en, sys_ce, busy;

  int n_chk = 0;
  int n_bad = 0;
  int hcnt  = 0;
  int lcnt  = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .idle_hi_en(idle_hi_en), .idle_lo_en(idle_lo_en),
    .halt_req(halt_req), .wake(wake), .hi_stable(hi_stable),
    .lo_clk_in(lo_clk_in), .mode(mode), .hi_osc_en(hi_osc_en),
    .lo_osc_en(lo_osc_en), .cpu_clk_en(cpu_clk_en), .sys_ce(sys_ce),
    .busy(busy)
  );

  // High-speed oscillator model: stable WARM_CYC cycles after enable
  always @(negedge clk) begin
    if (!hi_osc_en) begin
      hcnt      <= 0;
      hi_stable <= 1'b0;
    end else if (hcnt < WARM_CYC) hcnt <= hcnt + 1;
    else hi_stable <= 1'b1;
  end

  // Low-speed clock: period 16 reference cycles
  always @(negedge clk) begin
    if (lcnt == 7) begin
      lcnt      <= 0;
      lo_clk_in <= ~lo_clk_in;
    end else lcnt <= lcnt + 1;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_interval(output int n);
    int guard = 0;
    while (!sys_ce && guard < 500) begin tick(); guard++; end
    n = 0;
    do begin tick(); n++; end while (!sys_ce && n < 500);
  endtask

  task automatic wait_fast();
    int guard = 0;
    while ((busy || mode != 3'd0) && guard < 500) begin tick(); guard++; end
    chk("R8 reaches FAST after stable", int'(mode), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clk_sel = 3'd0; idle_hi_en = 0; idle_lo_en = 0;
    halt_req = 0; wake = 0;
    repeat (4) tick();
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 mode in reset", int'(mode), 1);
    chk("R1 hi_osc_en in reset", int'(hi_osc_en), 1);
    chk("R1 lo_osc_en in reset", int'(lo_osc_en), 1);
    chk("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
    chk("R1 sys_ce in reset", int'(sys_ce), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 still waiting after release", int'(busy), 1);
    wait_fast();
  endtask

  task automatic t_fast_ratios();
    int n;
    for (int k = 0; k <= 6; k++) begin
      clk_sel = 3'(k);
      get_interval(n);
      get_interval(n);
      chk($sformatf("R3 interval sel=%0d", k), n, 1 << k);
    end
  endtask

  task automatic t_ratio_boundary();
    int n, k;
    clk_sel = 3'd3;
    get_interval(n);
    get_interval(n);
    tick(); tick();
    clk_sel = 3'd5;
    k = 2;
    do begin tick(); k++; end while (!sys_ce && k < 500);
    chk("R4 period in progress keeps old ratio", k, 8);
    get_interval(n);
    chk("R4 next period uses new ratio", n, 32);
  endtask

  task automatic t_slow();
    int n;
    clk_sel = 3'd7;
    tick();
    chk("R2 mode SLOW", int'(mode), 1);
    chk("R2 hi_osc_en off", int'(hi_osc_en), 0);
    chk("R2 lo_osc_en on", int'(lo_osc_en), 1);
    chk("R2 not busy", int'(busy), 0);
    get_interval(n);
    get_interval(n);
    chk("R2 strobe follows low clock", n, 16);
  endtask

  task automatic t_slow_to_fast();
    int n;
    repeat (5) tick();
    clk_sel = 3'd2;
    tick();
    chk("R8 wait mode code", int'(mode), 1);
    chk("R8 busy during wait", int'(busy), 1);
    chk("R8 hi_osc_en during wait", int'(hi_osc_en), 1);
    get_interval(n);
    get_interval(n);
    chk("R8 low source during wait", n, 16);
    chk("R8 still busy", int'(busy), 1);
    wait_fast();
    get_interval(n);
    get_interval(n);
    chk("R8 ratio after switch", n, 4);
  endtask

  task automatic t_halt_modes();
    int seen;
    for (int c = 0; c < 4; c++) begin
      int exp_mode, exp_hi, exp_lo;
      clk_sel = 3'd0;
      idle_hi_en = c[1]; idle_lo_en = c[0];
      exp_hi = c[1]; exp_lo = c[0];
      exp_mode = (c == 0) ? 2 : (c == 1) ? 3 : (c == 3) ? 4 : 5;
      halt_req = 1'b1;
      tick();
      halt_req = 1'b0;
      chk($sformatf("R5 mode code c=%0d", c), int'(mode), exp_mode);
      chk($sformatf("R5 hi_osc_en c=%0d", c), int'(hi_osc_en), exp_hi);
      chk($sformatf("R5 lo_osc_en c=%0d", c), int'(lo_osc_en), exp_lo);
      chk($sformatf("R6 cpu gated c=%0d", c), int'(cpu_clk_en), 0);
      tick();
      seen = 0;
      repeat (40) begin if (sys_ce) seen++; tick(); end
      chk($sformatf("R6 no strobes c=%0d", c), seen, 0);
      wake = 1'b1;
      tick();
      wake = 1'b0;
      chk($sformatf("R7 wake mode c=%0d", c), int'(mode), exp_hi ? 0 : 1);
      chk($sformatf("R7 wake busy c=%0d", c), int'(busy), exp_hi ? 0 : 1);
      wait_fast();
    end
  endtask

  task automatic t_wake_slow();
    clk_sel = 3'd7;
    tick();
    idle_hi_en = 0; idle_lo_en = 0;
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    chk("R5 SLEEP from SLOW", int'(mode), 2);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R7 wake to SLOW", int'(mode), 1);
    chk("R7 wake to SLOW not busy", int'(busy), 0);
  endtask

  task automatic t_priority();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R9 wake ignored in SLOW", int'(mode), 1);
    chk("R9 wake ignored cpu on", int'(cpu_clk_en), 1);
    idle_hi_en = 1; idle_lo_en = 1;
    clk_sel = 3'd0;
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    chk("R9 halt beats select change", int'(mode), 4);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R7 wake into wait", int'(busy), 1);
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    chk("R9 halt ignored while waiting busy", int'(busy), 1);
    chk("R9 halt ignored while waiting cpu", int'(cpu_clk_en), 1);
    wait_fast();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fast_ratios();
    t_ratio_boundary();
    t_slow();
    t_slow_to_fast();
    t_halt_modes();
    t_wake_slow();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule